// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C target that gives a bus controller access to a small bank of byte-wide registers. After a START and a matching 7-bit address with the write direction, the first byte is a command. It loads a pointer that selects one register and sets an auto-step flag. Each data byte that follows in the same write goes to the register under the pointer. A read, whether it comes after a STOP or a repeated START, returns register contents starting at the pointer.

The register bank has ten slots. Slots 0 and 1 are read-only. They return a synchronized snapshot of two external input bytes. Slots 2 to 9 are read/write bytes and are exported for the neighbouring blocks to use: two frequency-divider settings, two duty settings and four output-mode selectors. When the auto-step flag is set, the pointer moves on by one after every byte transferred. After slot 9 it wraps to slot 0. SCL and SDA are sampled through two-flop synchronizers on the system clock. SDA is open-drain and is driven only as a pull-low enable.

Top module: `ptr_reg_target`

## Requirements
- R1: After reset the block does not pull SDA low, all eight read/write registers read as 00h, and the pointer and auto-step flag are zero.
- R2: After a START, the block acknowledges an address byte whose upper seven bits equal `devAddr`. Bit 0 of that byte gives the direction: 0 means write, 1 means read. For any other address it leaves SDA released and ignores every byte until the next START.
- R3: In an addressed write, every byte after the address is acknowledged. This includes bytes aimed at read-only or unused selects.
- R4: In the command byte, bits 3:0 set the pointer and bit 4 sets the auto-step flag. Bits 7:5 have no effect.
- R5: A data byte after the command is stored in register p when the pointer p is in the range 2 to 9. Register p appears on `regOut[8*(p-2)+7 : 8*(p-2)]`. Data written to selects 0, 1 and 10 to 15 leaves every register unchanged.
- R6: With the auto-step flag set, the 4-bit pointer increments after each byte read or written. Select 9 steps to 0, and select 15 steps to 0. With the flag clear, the pointer stays put.
- R7: Read bytes are sent MSB first. Select 0 returns `capIn[7:0]` and select 1 returns `capIn[15:8]`, each sampled as that byte is loaded for sending. Selects 2 to 9 return the stored registers, and selects 10 to 15 return 00h.
- R8: In a read, a controller ACK (SDA low on the ninth clock) makes the block send the next byte. After a NACK the block keeps SDA released through any further clocks until a STOP or START.
- R9: A STOP or a repeated START ends the current transfer and returns the block to address reception. The pointer and the flag are kept, so a later read continues from the pointer.
- R10: The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sdaDrvLow | output | 1 | When high, the block pulls SDA low |
| devAddr | input | 7 | The block's own bus address |
| capIn | input | 16 | Two external input bytes (byte 0 is select 0) |
| regOut | output | 64 | Read/write registers 2 to 9, with register 2 in the low byte |

## Verification
The bench writes a full auto-stepping run past slot 9. This catches a pointer that stops at 9, or one that lets the wrapped bytes overwrite slot 2 before the intended byte arrives. It changes an input byte partway through a read, so a block that latched its inputs once at the start of the transfer returns stale data on the wrapped read. It sends a command with bits 7:5 set, stepping from 15, and an unused select. A design that decoded the command too widely, or that returned garbage for high selects, shows wrong register contents or a non-zero read. It also clocks the bus after a NACK and uses a wrong address. A block that kept transmitting or answered a foreign address would pull SDA low where the bench expects it released.

// File: rtl/ptr_reg_pkg.sv
package ptr_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } busState_t;

  typedef struct packed {
    logic rxShift;
    logic loadCmd;
    logic writeReg;
    logic loadTx;
    logic txShift;
  } dpStrobe_t;

endpackage

// File: rtl/ptr_reg_sync.sv
module ptr_reg_sync #(
  parameter int W = 1,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] RST_VAL = RST_HIGH ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/ptr_reg_ctrl.sv
module ptr_reg_ctrl
  import ptr_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclSync,
  input  logic              sdaSync,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strobe,
  output logic              sdaDrvLow,
  output logic              stopDet
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  busState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic            sclPrev, sdaPrev;
  logic            isAddr, isRead, cmdNext, mAck;
  logic            sclRise, sclFall, startDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  // strobes toward the datapath
  always_comb begin
    strobe = '0;
    unique case (state)
      ST_RX: begin
        strobe.rxShift = sclRise && (bitCnt < FULL);
        if (sclFall && bitCnt == FULL && !isAddr) begin
          strobe.loadCmd  = cmdNext;
          strobe.writeReg = !cmdNext;
        end
      end
      ST_ACK:  strobe.loadTx  = sclFall && isRead;
      ST_TX:   strobe.txShift = sclFall && bitCnt != FULL;
      ST_MACK: strobe.loadTx  = sclFall && mAck;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isAddr  <= 1'b0;
      isRead  <= 1'b0;
      cmdNext <= 1'b0;
      mAck    <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      bitCnt <= '0;
      isAddr <= 1'b1;
      isRead <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == FULL) begin
            bitCnt <= '0;
            isAddr <= 1'b0;
            if (isAddr) begin
              if (rxByte[DATA_W-1 -: ADDR_W] == devAddr) begin
                state   <= ST_ACK;
                isRead  <= rxByte[0];
                cmdNext <= ~rxByte[0];
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cmdNext <= 1'b0;
              state   <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= isRead ? ST_TX : ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == FULL) begin
            bitCnt <= '0;
            state  <= ST_MACK;
          end
        end
        ST_MACK: begin
          if (sclRise) mAck <= ~sdaSync;
          if (sclFall) state <= mAck ? ST_TX : ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  assign sdaDrvLow = (state == ST_ACK) || (state == ST_TX && !txBit);
endmodule

// File: rtl/ptr_reg_dp.sv
module ptr_reg_dp
  import ptr_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 2,
  parameter int NUM_RW = 8,
  parameter int PTR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic                     sdaSync,
  input  logic [NUM_IN*DATA_W-1:0] capSync,
  output logic [DATA_W-1:0]        rxByte,
  output logic                     txBit,
  output logic [NUM_RW*DATA_W-1:0] regOut,
  output logic [PTR_W-1:0]         ptr,
  output logic                     ai
);
  localparam int NUM_REGS = NUM_IN + NUM_RW;
  localparam int SLOTS    = 1 << PTR_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] rxReg, txReg, rdByte;
  logic [DATA_W-1:0] rwReg [NUM_RW];
  logic [DATA_W-1:0] rdArr [SLOTS];
  logic              stepPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxReg <= '0;
    else if (strobe.rxShift) rxReg <= {rxReg[DATA_W-2:0], sdaSync};
  end
  assign rxByte = rxReg;

  // pointer and auto-step flag
  assign stepPtr = ai && (strobe.writeReg || strobe.loadTx);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      ai  <= 1'b0;
    end else if (strobe.loadCmd) begin
      ptr <= rxReg[PTR_W-1:0];
      ai  <= rxReg[PTR_W];
    end else if (stepPtr) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // read/write bank, one slot per generate step
  for (genvar k = 0; k < NUM_RW; k++) begin : g_rw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rwReg[k] <= '0;
      else if (strobe.writeReg && ptr == PTR_W'(k + NUM_IN)) rwReg[k] <= rxReg;
    end
    assign regOut[k*DATA_W +: DATA_W] = rwReg[k];
  end

  // read view of every pointer value
  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    if (s < NUM_IN) begin : g_cap
      assign rdArr[s] = capSync[s*DATA_W +: DATA_W];
    end else if (s < NUM_REGS) begin : g_reg
      assign rdArr[s] = rwReg[s-NUM_IN];
    end else begin : g_none
      assign rdArr[s] = '0;
    end
  end
  assign rdByte = rdArr[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txReg <= '1;
    else if (strobe.loadTx)  txReg <= rdByte;
    else if (strobe.txShift) txReg <= {txReg[DATA_W-2:0], 1'b1};
  end
  assign txBit = txReg[DATA_W-1];
endmodule

// File: rtl/ptr_reg_target.sv
module ptr_reg_target
  import ptr_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int NUM_IN = 2,
  parameter int NUM_RW = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaDrvLow,
  input  logic [ADDR_W-1:0]        devAddr,
  input  logic [NUM_IN*DATA_W-1:0] capIn,
  output logic [NUM_RW*DATA_W-1:0] regOut
);
  localparam int PTR_W = 4;

  logic             sclSync, sdaSync, stopDet, ai, txBit;
  logic [NUM_IN*DATA_W-1:0] capSync;
  logic [DATA_W-1:0] rxByte;
  logic [PTR_W-1:0] ptr;
  dpStrobe_t        strobe;

  ptr_reg_sync #(.W(2), .RST_HIGH(1'b1)) u_busSync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout({sclSync, sdaSync})
  );

  ptr_reg_sync #(.W(NUM_IN*DATA_W), .RST_HIGH(1'b0)) u_capSync (
    .clk(clk), .rstN(rstN), .din(capIn), .dout(capSync)
  );

  ptr_reg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaSync(sdaSync),
    .devAddr(devAddr), .rxByte(rxByte), .txBit(txBit),
    .strobe(strobe), .sdaDrvLow(sdaDrvLow), .stopDet(stopDet)
  );

  ptr_reg_dp #(.DATA_W(DATA_W), .NUM_IN(NUM_IN), .NUM_RW(NUM_RW), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaSync(sdaSync),
    .capSync(capSync), .rxByte(rxByte), .txBit(txBit),
    .regOut(regOut), .ptr(ptr), .ai(ai)
  );
endmodule

// File: rtl/ptr_reg_target_chk.sv
module ptr_reg_target_chk
  import ptr_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 2,
  parameter int NUM_RW = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sclSync,
  input logic                     sdaDrvLow,
  input logic                     stopDet,
  input dpStrobe_t                strobe,
  input logic [3:0]               ptr,
  input logic                     ai,
  input logic [NUM_RW*DATA_W-1:0] regOut
);
  localparam logic [3:0] LAST = 4'(NUM_IN + NUM_RW - 1);

  // R10
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclSync);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDrvLow);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == LAST && ai && (strobe.writeReg || strobe.loadTx)) |=> ptr == 4'd0);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadCmd || strobe.writeReg || strobe.loadTx) |=> ($stable(ptr) && $stable(ai)));

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeReg |=> $stable(regOut));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCmd, strobe.writeReg, strobe.loadTx}));
endmodule

bind ptr_reg_target ptr_reg_target_chk #(
  .DATA_W(DATA_W), .NUM_IN(NUM_IN), .NUM_RW(NUM_RW)
) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaDrvLow(sdaDrvLow),
  .stopDet(stopDet), .strobe(strobe), .ptr(ptr), .ai(ai), .regOut(regOut)
);

// File: tb/sim_ptr_reg_target.sv
module sim_ptr_reg_target;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        sclLine = 1'b1;
  logic        mLow = 1'b0;
  logic        sdaDrvLow;
  logic        sdaLine;
  logic [15:0] capIn = 16'hC35A;
  logic [63:0] regOut;
  logic [7:0]  mReg [2:9];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  string      expReq[$];
  logic [7:0] expVal[$];
  logic [7:0] obsVal[$];

  assign sdaLine = ~(mLow | sdaDrvLow);

  ptr_reg_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .devAddr(DEV), .capIn(capIn), .regOut(regOut)
  );

  // monitor: pairs bus observations with queued expectations
  initial forever begin
    @(negedge clk);
    if (expVal.size() > 0 && obsVal.size() > 0) begin
      automatic string      r = expReq.pop_front();
      automatic logic [7:0] e = expVal.pop_front();
      automatic logic [7:0] o = obsVal.pop_front();
      checks++;
      if (o !== e) begin
        errors++;
        $display("FAIL %s bus actual=%h expected=%h", r, o, e);
      end
    end
  end

  task automatic waitC(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model();
    logic [63:0] v;
    for (int p = 2; p <= 9; p++) v[(p-2)*8 +: 8] = mReg[p];
    return v;
  endfunction

  task automatic sendBit(bit b);
    waitC(Q); mLow = !b; waitC(Q); sclLine = 1'b1; waitC(2*Q); sclLine = 1'b0;
  endtask

  task automatic recvBit(output bit b);
    waitC(Q); mLow = 1'b0; waitC(Q); sclLine = 1'b1; waitC(Q); b = sdaLine; waitC(Q); sclLine = 1'b0;
  endtask

  task automatic startC();
    waitC(Q); mLow = 1'b1; waitC(2*Q); sclLine = 1'b0;
  endtask

  task automatic rstartC();
    waitC(Q); mLow = 1'b0; waitC(Q); sclLine = 1'b1; waitC(2*Q); mLow = 1'b1; waitC(2*Q); sclLine = 1'b0;
  endtask

  task automatic stopC();
    waitC(Q); mLow = 1'b1; waitC(Q); sclLine = 1'b1; waitC(2*Q); mLow = 1'b0; waitC(4*Q);
  endtask

  // driver: send a byte, expect ACK (0) or no ACK (1)
  task automatic sendByte(string req, logic [7:0] v, bit expAck);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    expReq.push_back(req); expVal.push_back({7'b0, !expAck});
    recvBit(b);
    obsVal.push_back({7'b0, b});
  endtask

  task automatic readByte(string req, logic [7:0] exp, bit ackIt);
    logic [7:0] v;
    bit b;
    expReq.push_back(req); expVal.push_back(exp);
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    obsVal.push_back(v);
    sendBit(!ackIt);
  endtask

  initial begin
    for (int p = 2; p <= 9; p++) mReg[p] = 8'h00;
    waitC(5);
    rstN = 1'b1;
    waitC(5);
    chk("R1", {63'b0, sdaDrvLow}, 64'd0);
    chk("R1", regOut, 64'd0);

    // auto-step write across slot 9 and wrap (R3 R5 R6)
    startC();
    sendByte("R2", {DEV, 1'b0}, 1'b1);
    sendByte("R3", 8'h12, 1'b1);
    for (int p = 2; p <= 9; p++) begin
      sendByte("R3", 8'h0F + 8'(p), 1'b1);
      mReg[p] = 8'h0F + 8'(p);
    end
    sendByte("R3", 8'hAA, 1'b1);
    sendByte("R3", 8'hBB, 1'b1);
    sendByte("R6", 8'hCC, 1'b1);
    mReg[2] = 8'hCC;
    stopC();
    chk("R5", regOut, model());

    // foreign address: no ACK, nothing stored (R2)
    startC();
    sendByte("R2", {DEV ^ 7'h01, 1'b0}, 1'b0);
    sendByte("R2", 8'h03, 1'b0);
    sendByte("R2", 8'h55, 1'b0);
    stopC();
    chk("R2", regOut, model());

    // read from slot 0 with repeated start, input changes mid-read (R7 R8 R9)
    startC();
    sendByte("R2", {DEV, 1'b0}, 1'b1);
    sendByte("R4", 8'h10, 1'b1);
    rstartC();
    sendByte("R9", {DEV, 1'b1}, 1'b1);
    readByte("R7", 8'h5A, 1'b1);
    readByte("R7", 8'hC3, 1'b1);
    for (int p = 2; p <= 9; p++) begin
      readByte("R8", mReg[p], 1'b1);
      if (p == 5) capIn[7:0] = 8'hA5;
    end
    readByte("R6", 8'hA5, 1'b0);
    for (int i = 0; i < 9; i++) begin
      bit b;
      expReq.push_back("R8"); expVal.push_back(8'h01);
      recvBit(b);
      obsVal.push_back({7'b0, b});
    end
    stopC();

    // fixed pointer: last write wins, later read keeps pointer (R6 R9)
    startC();
    sendByte("R2", {DEV, 1'b0}, 1'b1);
    sendByte("R4", 8'h05, 1'b1);
    sendByte("R3", 8'h77, 1'b1);
    sendByte("R3", 8'h66, 1'b1);
    mReg[5] = 8'h66;
    stopC();
    chk("R6", regOut, model());
    startC();
    sendByte("R9", {DEV, 1'b1}, 1'b1);
    readByte("R9", 8'h66, 1'b1);
    readByte("R6", 8'h66, 1'b0);
    stopC();

    // command upper bits ignored; stepping from 15 reaches 0 (R4 R6)
    startC();
    sendByte("R2", {DEV, 1'b0}, 1'b1);
    sendByte("R4", 8'hF3, 1'b1);
    sendByte("R4", 8'h21, 1'b1);
    sendByte("R4", 8'h22, 1'b1);
    mReg[3] = 8'h21; mReg[4] = 8'h22;
    rstartC();
    sendByte("R2", {DEV, 1'b0}, 1'b1);
    sendByte("R4", 8'h1F, 1'b1);
    sendByte("R3", 8'h44, 1'b1);
    sendByte("R3", 8'h45, 1'b1);
    sendByte("R3", 8'h46, 1'b1);
    sendByte("R6", 8'h47, 1'b1);
    mReg[2] = 8'h47;
    stopC();
    chk("R4", regOut, model());

    // unused select: write ignored, reads 00h (R5 R7)
    startC();
    sendByte("R2", {DEV, 1'b0}, 1'b1);
    sendByte("R4", 8'h0C, 1'b1);
    sendByte("R3", 8'h99, 1'b1);
    rstartC();
    sendByte("R2", {DEV, 1'b1}, 1'b1);
    readByte("R7", 8'h00, 1'b0);
    stopC();
    chk("R5", regOut, model());
    chk("R10", {63'b0, sdaDrvLow}, 64'd0);

    waitC(20);
    if (expVal.size() != 0 || obsVal.size() != 0) begin
      checks++; errors++;
      $display("FAIL R8 unmatched items actual=%0d expected=%0d", obsVal.size(), expVal.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule